// File: doc/BRIEF.md
# Channel-Group Test Word Generator

This block sits between the converter core and the output coding stage of a multi-channel sampling front end. For each channel group it either forwards the live sample or replaces it with a synthetic test word. The output stage can therefore be exercised with known data, without any analog input.

Each group has its own enable, a 2-bit mode, a step field and two pattern words, and these are independent of every other group. The modes give one of two constant words, an incrementing ramp with a programmable step, or a word that alternates between the two patterns on every sample. The output is registered and moves only on that group's sample strobe. Live data and test data both appear one clock after the strobe.

A ramp or alternation sequence restarts from its first value whenever the group's enable is dropped or its mode is moved away. The test equipment therefore always sees the sequence begin from a defined point.

Top module: `test_word_gen`

## Requirements
- R1: After reset, every group's output word is 0. The ramp state and the alternation phase start from 0 and pattern 0.
- R2: A group's output word changes only in the clock cycle after that group's sample strobe is high. Input changes without a strobe leave the output unchanged.
- R3: With the test enable low, a strobe loads the live sample present at that edge into the output, one clock later.
- R4: With the test enable high, mode 0 loads pattern 0 on each strobe and mode 1 loads pattern 1 on each strobe.
- R5: Mode 2 is a ramp. The first strobe after the ramp starts outputs 0, and each later strobe adds step+1, where step is the unsigned step field (increments 1 to 16).
- R6: The ramp wraps modulo 2^WIDTH.
- R7: Mode 3 outputs pattern 0 on the first strobe after the mode starts, then pattern 1, and toggles on every strobe after that.
- R8: Clearing the enable, or leaving mode 2 or mode 3, restarts that sequence. The next ramp output is 0 and the next alternating output is pattern 0, even when no strobe occurs in between.
- R9: Groups are independent. The strobe, enable, mode, step and patterns of one group never change another group's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb_i | input | NUM_GRP | Per-group sample strobe |
| live_i | input | NUM_GRP*WIDTH | Live samples, group g at bits [g*WIDTH +: WIDTH] |
| tst_en_i | input | NUM_GRP | Per-group test enable |
| mode_i | input | NUM_GRP*2 | Per-group mode: 0 pattern 0, 1 pattern 1, 2 ramp, 3 alternate |
| step_i | input | NUM_GRP*STEP_W | Per-group ramp step field (increment = value+1) |
| pat0_i | input | NUM_GRP*WIDTH | Per-group pattern 0 |
| pat1_i | input | NUM_GRP*WIDTH | Per-group pattern 1 |
| smp_o | output | NUM_GRP*WIDTH | Per-group selected output word |

## Verification
The bench builds the block with WIDTH=8, STEP_W=4 and NUM_GRP=2. The narrow word brings the ramp wrap within 16 strobes at the largest step. The two groups let the bench strobe one group while the other holds a ramp mid-sequence, so any leak of state between groups shows up. The default 24-bit width uses the same logic and only lengthens the wrap period.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    TPG_FIX0 = 2'd0,
    TPG_FIX1 = 2'd1,
    TPG_RAMP = 2'd2,
    TPG_ALT  = 2'd3
  } tpg_mode_e;
endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int WIDTH  = 24,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [WIDTH-1:0]  val_o
);
  localparam int PAD_W = WIDTH - STEP_W;

  logic [WIDTH-1:0] inc;
  logic [WIDTH-1:0] val_d, val_q;

  assign inc = {{PAD_W{1'b0}}, step_i} + {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    val_d = val_q;
    if (clr_i)      val_d = '0;
    else if (adv_i) val_d = val_q + inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;

  a_r8_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (val_o == '0));
  a_r5_hold_no_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(val_o));
endmodule

// File: rtl/tpg_alt_phase.sv
module tpg_alt_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic phase_o
);
  logic phase_d, phase_q;

  always_comb begin
    phase_d = phase_q;
    if (clr_i)      phase_d = 1'b0;
    else if (adv_i) phase_d = ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  a_r7_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (phase_o != $past(phase_o)));
endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
  import tpg_pkg::*;
#(
  parameter int WIDTH  = 24,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [WIDTH-1:0]  live_i,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [WIDTH-1:0]  pat0_i,
  input  logic [WIDTH-1:0]  pat1_i,
  output logic [WIDTH-1:0]  out_o
);
  tpg_mode_e        mode;
  logic             ramp_clr, ramp_adv, alt_clr, alt_adv, phase;
  logic [WIDTH-1:0] ramp_val, sel, out_d, out_q;

  assign mode     = tpg_mode_e'(mode_i);
  assign ramp_clr = !en_i || (mode != TPG_RAMP);
  assign alt_clr  = !en_i || (mode != TPG_ALT);
  assign ramp_adv = stb_i && !ramp_clr;
  assign alt_adv  = stb_i && !alt_clr;

  tpg_ramp #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ramp_clr),
    .adv_i  (ramp_adv),
    .step_i (step_i),
    .val_o  (ramp_val)
  );

  tpg_alt_phase u_alt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (alt_clr),
    .adv_i   (alt_adv),
    .phase_o (phase)
  );

  always_comb begin
    if (!en_i) begin
      sel = live_i;
    end else begin
      unique case (mode)
        TPG_FIX0: sel = pat0_i;
        TPG_FIX1: sel = pat1_i;
        TPG_RAMP: sel = ramp_val;
        TPG_ALT:  sel = phase ? pat1_i : pat0_i;
        default:  sel = pat0_i;
      endcase
    end
  end

  always_comb begin
    out_d = out_q;
    if (stb_i) out_d = sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(out_o));
  a_r3_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !en_i) |=> (out_o == $past(live_i)));
  a_r4_fix0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && en_i && mode_i == 2'd0) |=> (out_o == $past(pat0_i)));
  a_r4_fix1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && en_i && mode_i == 2'd1) |=> (out_o == $past(pat1_i)));
  a_r7_alt_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && en_i && mode_i == 2'd3 && !phase) |=> (out_o == $past(pat0_i) && phase));
  a_r8_alt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_clr |=> !phase);
endmodule

// File: rtl/test_word_gen.sv
module test_word_gen #(
  parameter int WIDTH   = 24,
  parameter int STEP_W  = 4,
  parameter int NUM_GRP = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_GRP-1:0]        smp_stb_i,
  input  logic [NUM_GRP*WIDTH-1:0]  live_i,
  input  logic [NUM_GRP-1:0]        tst_en_i,
  input  logic [NUM_GRP*2-1:0]      mode_i,
  input  logic [NUM_GRP*STEP_W-1:0] step_i,
  input  logic [NUM_GRP*WIDTH-1:0]  pat0_i,
  input  logic [NUM_GRP*WIDTH-1:0]  pat1_i,
  output logic [NUM_GRP*WIDTH-1:0]  smp_o
);
  logic rst_n;

  tpg_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tpg_channel #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .stb_i  (smp_stb_i[g]),
      .live_i (live_i[g*WIDTH +: WIDTH]),
      .en_i   (tst_en_i[g]),
      .mode_i (mode_i[g*2 +: 2]),
      .step_i (step_i[g*STEP_W +: STEP_W]),
      .pat0_i (pat0_i[g*WIDTH +: WIDTH]),
      .pat1_i (pat1_i[g*WIDTH +: WIDTH]),
      .out_o  (smp_o[g*WIDTH +: WIDTH])
    );
  end

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_n |=> (smp_o == '0));
endmodule

// File: tb/tb_test_word_gen.sv
module tb_test_word_gen;
  localparam int W  = 8;
  localparam int SW = 4;
  localparam int NG = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NG-1:0] stb, en;
  logic [W-1:0]  live [NG];
  logic [1:0]    mode [NG];
  logic [SW-1:0] step [NG];
  logic [W-1:0]  p0 [NG];
  logic [W-1:0]  p1 [NG];
  logic [NG*W-1:0]  live_v, p0_v, p1_v, out_v;
  logic [NG*2-1:0]  mode_v;
  logic [NG*SW-1:0] step_v;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      live_v[g*W +: W]   = live[g];
      p0_v[g*W +: W]     = p0[g];
      p1_v[g*W +: W]     = p1[g];
      mode_v[g*2 +: 2]   = mode[g];
      step_v[g*SW +: SW] = step[g];
    end
  end

  test_word_gen #(.WIDTH(W), .STEP_W(SW), .NUM_GRP(NG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .live_i(live_v),
    .tst_en_i(en), .mode_i(mode_v), .step_i(step_v),
    .pat0_i(p0_v), .pat1_i(p1_v), .smp_o(out_v));

  function automatic logic [W-1:0] grp_out(int g);
    return out_v[g*W +: W];
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic pulse(logic [NG-1:0] m);
    @(negedge clk) stb = m;
    @(negedge clk) stb = '0;
  endtask

  task automatic t_reset;
    chk("R1 grp0 reset", grp_out(0), '0);
    chk("R1 grp1 reset", grp_out(1), '0);
  endtask

  task automatic t_live;
    en[0] = 0; live[0] = 8'h5A;
    pulse(2'b01);
    chk("R3 live word", grp_out(0), 8'h5A);
    live[0] = 8'hC3;
    @(negedge clk); @(negedge clk);
    chk("R2 no strobe hold", grp_out(0), 8'h5A);
    pulse(2'b01);
    chk("R3 live update", grp_out(0), 8'hC3);
  endtask

  task automatic t_fixed;
    en[0] = 1; mode[0] = 2'd0; p0[0] = 8'h11; p1[0] = 8'h22;
    pulse(2'b01);
    chk("R4 mode0 pat0", grp_out(0), 8'h11);
    mode[0] = 2'd1;
    @(negedge clk);
    chk("R2 mode change no strobe", grp_out(0), 8'h11);
    pulse(2'b01);
    chk("R4 mode1 pat1", grp_out(0), 8'h22);
  endtask

  task automatic t_ramp;
    mode[0] = 2'd2; step[0] = 4'd2;
    for (int i = 0; i < 4; i++) begin
      pulse(2'b01);
      chk("R5 ramp step 3", grp_out(0), W'(i * 3));
    end
  endtask

  task automatic t_restart;
    mode[0] = 2'd0;
    @(negedge clk) mode[0] = 2'd2;
    pulse(2'b01);
    chk("R8 ramp restart on mode", grp_out(0), 8'd0);
    pulse(2'b01);
    chk("R5 ramp resumes", grp_out(0), 8'd3);
    en[0] = 0;
    @(negedge clk) en[0] = 1;
    pulse(2'b01);
    chk("R8 ramp restart on enable", grp_out(0), 8'd0);
  endtask

  task automatic t_wrap;
    mode[0] = 2'd0;
    @(negedge clk) begin mode[0] = 2'd2; step[0] = 4'd15; end
    for (int i = 0; i < 17; i++) begin
      pulse(2'b01);
      chk("R6 ramp wrap", grp_out(0), W'(i * 16));
    end
  endtask

  task automatic t_alt;
    mode[0] = 2'd3; p0[0] = 8'hA0; p1[0] = 8'h0B;
    for (int i = 0; i < 4; i++) begin
      pulse(2'b01);
      chk("R7 alternate", grp_out(0), (i % 2 == 0) ? 8'hA0 : 8'h0B);
    end
    mode[0] = 2'd1;
    @(negedge clk) mode[0] = 2'd3;
    pulse(2'b01);
    chk("R8 alternate restart", grp_out(0), 8'hA0);
  endtask

  task automatic t_indep;
    logic [W-1:0] g0;
    mode[0] = 2'd0;
    @(negedge clk) begin mode[0] = 2'd2; step[0] = 4'd0; end
    pulse(2'b01);
    pulse(2'b01);
    g0 = grp_out(0);
    chk("R5 ramp step 1", g0, 8'd1);
    en[1] = 0; live[1] = 8'h77;
    pulse(2'b10);
    chk("R9 grp1 live", grp_out(1), 8'h77);
    chk("R9 grp0 untouched", grp_out(0), g0);
    en[1] = 1; mode[1] = 2'd3; p0[1] = 8'h44; p1[1] = 8'h99; step[1] = 4'd7;
    pulse(2'b11);
    chk("R9 grp1 alt", grp_out(1), 8'h44);
    chk("R9 grp0 ramp continues", grp_out(0), 8'd2);
  endtask

  initial begin
    rst_n = 0; stb = '0; en = '0;
    for (int g = 0; g < NG; g++) begin
      live[g] = '0; mode[g] = '0; step[g] = '0; p0[g] = '0; p1[g] = '0;
    end
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_live;
    t_fixed;
    t_ramp;
    t_restart;
    t_wrap;
    t_alt;
    t_indep;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule